// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the bus-capture stage of a byte-wide NOR-style flash controller. Each captured write (address plus data byte) arrives as a one-cycle event. The block checks these writes against the multi-write unlock protocol and keeps a mode register. Correct sequences move it into one of several modes: plain array reads, identification, fast-program (unlock bypass), a running program, or a latched fault. A finished program command raises a one-cycle start strobe toward the embedded program engine. The strobe carries the captured target address and data byte.

The engine reports completion with a done pulse and an optional fail flag. While the engine works, and after a failure, reads return the engine's status byte. In identification mode, reads return fixed identity bytes or the protection bit of the addressed block. In every other mode, reads pass the array data through. A per-block protection vector is an input. A program aimed at a protected block is dropped without a trace.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, mode_o is 0 (read), prog_start is low and rd_data equals array_data. The mode codes are: 0 read, 1 identification, 2 fast-program, 3 program busy, 4 fault.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then a data write start a program, with offsets compared on address bits 10:0. prog_start is high for exactly one cycle after the data write, with prog_addr and prog_data equal to that write. mode_o becomes 3.
- R3: A program whose data write falls in a block with blk_prot[addr[20:16]] set gives no prog_start. The mode stays where it was: read, or fast-program.
- R4: In mode 3, writes are ignored and rd_data equals eng_status. On eng_done with eng_fail low, the mode returns to read, or to fast-program if the program was started from there.
- R5: On eng_done with eng_fail high, the mode becomes 4. There rd_data equals eng_status, and other writes leave the mode unchanged. A single F0h write, or AAh@555h, 55h@2AAh, F0h@555h, leaves mode 4 for read, or for fast-program if the program was started from there.
- R6: AAh@555h, 55h@2AAh, 90h@555h enters mode 1. In mode 1, rd_addr[1:0]=00 reads 20h, 01 reads C8h and 11 reads 00h.
- R7: In mode 1, rd_addr[1:0]=10 reads 01h when blk_prot[rd_addr[20:16]] is set, and 00h otherwise.
- R8: In mode 1, writes other than a single F0h or the three-write F0h form leave the mode at 1. Those two return it to read.
- R9: In read mode, a write that does not match the expected unlock step drops the sequence. A following data write then starts no program.
- R10: AAh@555h, 55h@2AAh, 20h@555h enters mode 2, where rd_data equals array_data.
- R11: In mode 2, A0h followed by a data write (any addresses) starts a program as in R2. A successful finish returns the mode to 2.
- R12: In mode 2, 90h followed by 00h returns to read mode, and other writes leave the mode at 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Captured bus write present this cycle |
| wr_addr | input | 21 | Address of the captured write |
| wr_data | input | 8 | Data byte of the captured write |
| rd_addr | input | 21 | Current read address |
| array_data | input | 8 | Array byte at rd_addr |
| blk_prot | input | 32 | Per-block protection bits |
| eng_status | input | 8 | Status byte from the program engine |
| eng_done | input | 1 | Engine finished pulse |
| eng_fail | input | 1 | Engine failure flag, valid with eng_done |
| prog_start | output | 1 | One-cycle program start strobe |
| prog_addr | output | 21 | Latched program address |
| prog_data | output | 8 | Latched program data |
| mode_o | output | 3 | Current mode code |
| rd_data | output | 8 | Read data returned to the bus |

## Verification
The program path is driven three ways:
- a clean four-write sequence;
- sequences broken at the offset, at the data, or by an early F0h;
- a complete sequence aimed at a protected block.

Together these separate a real start from a dropped prefix and from a silent drop. Engine finishes are given both with and without failure, from read and from fast-program. This shows whether the mode returns home correctly and whether the fault is held until one of the two reset forms. Identification reads sweep all four low-address codes, with a protected and an unprotected block. Stray writes in identification, busy, fault and fast-program show that each mode ignores what it must.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_IDENT = 3'd1,
    MD_FAST  = 3'd2,
    MD_BUSY  = 3'd3,
    MD_FAULT = 3'd4
  } fmode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_DATA,
    SQ_FEXIT
  } seq_e;

  localparam int          OFS_W     = 11;
  localparam logic [10:0] OFS_A     = 11'h555;
  localparam logic [10:0] OFS_B     = 11'h2AA;
  localparam logic [7:0]  KEY1      = 8'hAA;
  localparam logic [7:0]  KEY2      = 8'h55;
  localparam logic [7:0]  OP_IDENT  = 8'h90;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_FAST   = 8'h20;
  localparam logic [7:0]  OP_RESET  = 8'hF0;
  localparam logic [7:0]  OP_FCONF  = 8'h00;
endpackage

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]       wr_data,
  input  logic             tgt_locked,
  input  logic             eng_done,
  input  logic             eng_fail,
  output fmode_e           mode_q,
  output logic             launch
);
  seq_e   step_q, step_d;
  fmode_e mode_d, home;
  logic   fast_q, fast_d;
  logic   hit_a, hit_b, adv;

  assign hit_a = (wr_ofs == OFS_A);
  assign hit_b = (wr_ofs == OFS_B);
  assign home  = fast_q ? MD_FAST : MD_READ;
  assign adv   = wr_valid | eng_done;

  always_comb begin
    mode_d = mode_q;
    step_d = step_q;
    fast_d = fast_q;
    launch = 1'b0;
    unique case (mode_q)
      MD_READ: begin
        if (wr_valid) begin
          step_d = SQ_IDLE;
          case (step_q)
            SQ_IDLE: if (hit_a && wr_data == KEY1) step_d = SQ_KEY1;
            SQ_KEY1: if (hit_b && wr_data == KEY2) step_d = SQ_KEY2;
            SQ_KEY2: begin
              if (hit_a) begin
                if (wr_data == OP_IDENT) mode_d = MD_IDENT;
                else if (wr_data == OP_PROG) step_d = SQ_DATA;
                else if (wr_data == OP_FAST) begin
                  mode_d = MD_FAST;
                  fast_d = 1'b1;
                end
              end
            end
            SQ_DATA: begin
              if (!tgt_locked) begin
                launch = 1'b1;
                mode_d = MD_BUSY;
              end
            end
            default: ;
          endcase
        end
      end
      MD_IDENT, MD_FAULT: begin
        if (wr_valid) begin
          step_d = SQ_IDLE;
          case (step_q)
            SQ_IDLE: begin
              if (wr_data == OP_RESET) mode_d = home;
              else if (hit_a && wr_data == KEY1) step_d = SQ_KEY1;
            end
            SQ_KEY1: if (hit_b && wr_data == KEY2) step_d = SQ_KEY2;
            SQ_KEY2: if (hit_a && wr_data == OP_RESET) mode_d = home;
            default: ;
          endcase
        end
      end
      MD_FAST: begin
        if (wr_valid) begin
          step_d = SQ_IDLE;
          case (step_q)
            SQ_IDLE: begin
              if (wr_data == OP_PROG) step_d = SQ_DATA;
              else if (wr_data == OP_IDENT) step_d = SQ_FEXIT;
            end
            SQ_DATA: begin
              if (!tgt_locked) begin
                launch = 1'b1;
                mode_d = MD_BUSY;
              end
            end
            SQ_FEXIT: begin
              if (wr_data == OP_FCONF) begin
                mode_d = MD_READ;
                fast_d = 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      MD_BUSY: begin
        step_d = SQ_IDLE;
        if (eng_done) mode_d = eng_fail ? MD_FAULT : home;
      end
      default: begin
        mode_d = MD_READ;
        step_d = SQ_IDLE;
        fast_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
      step_q <= SQ_IDLE;
      fast_q <= 1'b0;
    end else if (adv) begin
      mode_q <= mode_d;
      step_q <= step_d;
      fast_q <= fast_d;
    end
  end
endmodule

// File: rtl/fcs_prog_latch.sv
module fcs_prog_latch #(
  parameter int AW      = 21,
  parameter int NBLK    = 32,
  parameter int BLK_LSB = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [NBLK-1:0] blk_prot,
  input  logic            launch,
  output logic            tgt_locked,
  output logic            prog_start,
  output logic [AW-1:0]   prog_addr,
  output logic [7:0]      prog_data
);
  localparam int BLK_W = $clog2(NBLK);

  logic [BLK_W-1:0] tgt_blk;
  assign tgt_blk    = wr_addr[BLK_LSB +: BLK_W];
  assign tgt_locked = blk_prot[tgt_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else begin
      prog_start <= launch;
      if (launch) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import fcs_pkg::*;
#(
  parameter int         AW      = 21,
  parameter int         NBLK    = 32,
  parameter int         BLK_LSB = 16,
  parameter logic [7:0] MFR_ID  = 8'h20,
  parameter logic [7:0] DEV_ID  = 8'hC8
) (
  input  fmode_e          mode,
  input  logic [AW-1:0]   rd_addr,
  input  logic [7:0]      array_data,
  input  logic [7:0]      eng_status,
  input  logic [NBLK-1:0] blk_prot,
  output logic [7:0]      rd_data
);
  localparam int BLK_W = $clog2(NBLK);

  logic [BLK_W-1:0] rd_blk;
  logic [7:0]       ident_byte;
  logic             unused_mid;

  assign rd_blk     = rd_addr[BLK_LSB +: BLK_W];
  assign unused_mid = ^rd_addr[BLK_LSB-1:2];

  always_comb begin
    case (rd_addr[1:0])
      2'b00:   ident_byte = MFR_ID;
      2'b01:   ident_byte = DEV_ID;
      2'b10:   ident_byte = {7'd0, blk_prot[rd_blk]};
      default: ident_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (mode)
      MD_IDENT:          rd_data = ident_byte;
      MD_BUSY, MD_FAULT: rd_data = eng_status;
      default:           rd_data = array_data;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int         AW      = 21,
  parameter int         NBLK    = 32,
  parameter int         BLK_LSB = 16,
  parameter logic [7:0] MFR_ID  = 8'h20,
  parameter logic [7:0] DEV_ID  = 8'hC8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic [7:0]      array_data,
  input  logic [NBLK-1:0] blk_prot,
  input  logic [7:0]      eng_status,
  input  logic            eng_done,
  input  logic            eng_fail,
  output logic            prog_start,
  output logic [AW-1:0]   prog_addr,
  output logic [7:0]      prog_data,
  output logic [2:0]      mode_o,
  output logic [7:0]      rd_data
);
  fmode_e mode;
  logic   launch, tgt_locked;

  fcs_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ofs     (wr_addr[OFS_W-1:0]),
    .wr_data    (wr_data),
    .tgt_locked (tgt_locked),
    .eng_done   (eng_done),
    .eng_fail   (eng_fail),
    .mode_q     (mode),
    .launch     (launch)
  );

  fcs_prog_latch #(.AW(AW), .NBLK(NBLK), .BLK_LSB(BLK_LSB)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .blk_prot   (blk_prot),
    .launch     (launch),
    .tgt_locked (tgt_locked),
    .prog_start (prog_start),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data)
  );

  fcs_read_mux #(.AW(AW), .NBLK(NBLK), .BLK_LSB(BLK_LSB),
                 .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rmux (
    .mode       (mode),
    .rd_addr    (rd_addr),
    .array_data (array_data),
    .eng_status (eng_status),
    .blk_prot   (blk_prot),
    .rd_data    (rd_data)
  );

  assign mode_o = mode;
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter logic [7:0] MFR_ID = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       eng_done,
  input logic       eng_fail,
  input logic [7:0] eng_status,
  input logic       prog_start,
  input logic [2:0] mode_o,
  input logic [1:0] rd_sel,
  input logic [7:0] rd_data
);
  // R2
  start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(wr_valid));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (mode_o == 3'd3));
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && !eng_done) |=> (mode_o == 3'd3));
  // R4
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3) |-> (rd_data == eng_status));
  // R5
  fail_to_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && eng_done && eng_fail) |=> (mode_o == 3'd4));
  // R5
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && !wr_valid) |=> (mode_o == 3'd4));
  // R6
  ident_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && rd_sel == 2'b00) |-> (rd_data == MFR_ID));
endmodule

bind flash_cmd_seq fcs_chk #(.MFR_ID(MFR_ID)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .eng_done   (eng_done),
  .eng_fail   (eng_fail),
  .eng_status (eng_status),
  .prog_start (prog_start),
  .mode_o     (mode_o),
  .rd_sel     (rd_addr[1:0]),
  .rd_data    (rd_data)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [20:0] rd_addr = '0;
  logic [7:0]  array_data;
  logic [31:0] blk_prot = 32'h0000_0004;
  logic [7:0]  eng_status = 8'hA5;
  logic        eng_done = 1'b0;
  logic        eng_fail = 1'b0;
  logic        prog_start;
  logic [20:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  mode_o;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  logic [28:0] exp_q[$];

  always #2 clk = ~clk;
  assign array_data = rd_addr[7:0] ^ 8'h3C;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .array_data(array_data),
    .blk_prot(blk_prot), .eng_status(eng_status), .eng_done(eng_done),
    .eng_fail(eng_fail), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .mode_o(mode_o), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every start strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && prog_start) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2/R3 unexpected start actual=%0h expected=none", {prog_addr, prog_data});
      end else begin
        logic [28:0] e;
        e = exp_q.pop_front();
        if ({prog_addr, prog_data} !== e) begin
          bad++;
          $display("FAIL R2 start actual=%0h expected=%0h", {prog_addr, prog_data}, e);
        end
      end
    end
  end

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] op);
    wr(21'h555, 8'hAA);
    wr(21'h2AA, 8'h55);
    wr(21'h555, op);
  endtask

  task automatic finish_eng(input logic f);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = f;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, input string req, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 mode", mode_o, 0);
    chk("R1 start", prog_start, 0);
    rd(21'h00_0123, "R1 read", 8'h23 ^ 8'h3C);

    // R2 four-write program
    exp_q.push_back({21'h01_2345, 8'h5A});
    cmd3(8'hA0);
    wr(21'h01_2345, 8'h5A);
    chk("R2 mode busy", mode_o, 3);
    rd(21'h0, "R4 busy status", 8'hA5);
    wr(21'h555, 8'hF0);
    chk("R4 write ignored", mode_o, 3);
    finish_eng(1'b0);
    chk("R4 back to read", mode_o, 0);

    // R3 protected target (block 2)
    cmd3(8'hA0);
    wr(21'h02_1000, 8'h77);
    chk("R3 stay read", mode_o, 0);
    rd(21'h02_1000, "R3 array unchanged view", 8'h00 ^ 8'h3C);

    // R9 broken sequences
    wr(21'h555, 8'hAA); wr(21'h2AB, 8'h55); wr(21'h555, 8'hA0); wr(21'h00_0100, 8'h66);
    chk("R9 bad offset", mode_o, 0);
    wr(21'h555, 8'hAA); wr(21'h2AA, 8'h54); wr(21'h555, 8'hA0); wr(21'h00_0100, 8'h66);
    chk("R9 bad data", mode_o, 0);
    cmd3(8'hF0); wr(21'h00_0100, 8'h66);
    chk("R9 reset mid", mode_o, 0);

    // R5 fault, single-write exit
    exp_q.push_back({21'h1F_0001, 8'h11});
    cmd3(8'hA0); wr(21'h1F_0001, 8'h11);
    finish_eng(1'b1);
    chk("R5 fault", mode_o, 4);
    rd(21'h0, "R5 status", 8'hA5);
    wr(21'h0, 8'h00);
    chk("R5 hold", mode_o, 4);
    wr(21'h0, 8'hF0);
    chk("R5 single exit", mode_o, 0);
    // R5 three-write exit
    exp_q.push_back({21'h1E_0002, 8'h22});
    cmd3(8'hA0); wr(21'h1E_0002, 8'h22);
    finish_eng(1'b1);
    cmd3(8'hF0);
    chk("R5 three exit", mode_o, 0);

    // R6 / R7 identification
    cmd3(8'h90);
    chk("R6 mode", mode_o, 1);
    rd(21'h00_0000, "R6 mfr", 8'h20);
    rd(21'h00_0001, "R6 dev", 8'hC8);
    rd(21'h00_0003, "R6 other", 8'h00);
    rd(21'h02_0002, "R7 protected", 8'h01);
    rd(21'h03_0002, "R7 open", 8'h00);
    // R8
    wr(21'h555, 8'hA0);
    chk("R8 ignore", mode_o, 1);
    cmd3(8'hA0);
    chk("R8 ignore seq", mode_o, 1);
    wr(21'h0, 8'hF0);
    chk("R8 single exit", mode_o, 0);
    cmd3(8'h90);
    cmd3(8'hF0);
    chk("R8 three exit", mode_o, 0);

    // R10 fast-program mode
    cmd3(8'h20);
    chk("R10 mode", mode_o, 2);
    rd(21'h00_0055, "R10 read", 8'h55 ^ 8'h3C);
    // R11
    exp_q.push_back({21'h0A_0042, 8'h3C});
    wr(21'h0, 8'hA0); wr(21'h0A_0042, 8'h3C);
    chk("R11 busy", mode_o, 3);
    finish_eng(1'b0);
    chk("R11 home", mode_o, 2);
    exp_q.push_back({21'h0B_0001, 8'h01});
    wr(21'h0, 8'hA0); wr(21'h0B_0001, 8'h01);
    finish_eng(1'b1);
    chk("R5 fault from fast", mode_o, 4);
    wr(21'h0, 8'hF0);
    chk("R5 exit to fast", mode_o, 2);
    wr(21'h0, 8'hA0); wr(21'h02_0010, 8'h99);
    chk("R3 fast protected", mode_o, 2);
    // R12
    wr(21'h0, 8'h55);
    chk("R12 ignore", mode_o, 2);
    wr(21'h0, 8'h90); wr(21'h0, 8'h00);
    chk("R12 exit", mode_o, 0);
    wr(21'h0, 8'hA0); wr(21'h0C_0000, 8'h12);
    chk("R12 bypass gone", mode_o, 0);

    repeat (3) @(negedge clk);
    chk("R2 all starts seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule